// File: doc/BRIEF.md
# Three-Channel Address-Steered Packet Router

The router takes byte-serial packets on one input port and delivers each one to one of three output queues. The first byte of a packet is a header. Its low two bits name the destination queue and its upper six bits give the number of payload bytes that follow. After the payload comes a single check byte. An input state machine frames the packet. It keeps a running XOR of the header and payload, compares the result with the check byte, and raises `err` when the two differ.

A steering stage converts the destination held by the state machine into the write strobe of exactly one queue. When that queue is full, the router raises `suspend`, and the sender must hold its byte until `suspend` falls. Each queue is 16 bytes deep and shows its oldest byte on its own data port, together with a valid flag. A byte leaves the queue on each clock edge at which that queue's read enable is high. If a queue's reader does not start draining within 30 cycles of the valid flag rising, the queue is emptied.

The input state machine has three states:
- Idle waits for a header. It moves to Body when the header length is non-zero, and to Parity when the length is zero.
- Body counts payload bytes and moves to Parity on the last payload byte.
- Parity takes the check byte and returns to Idle.

Every transition happens only on an accepted byte. A byte is accepted on an edge where `pkt_valid` is high and `suspend` is low.

Top module: `pkt_router3`

## Requirements
- R1: Reset is synchronous and active-low. It empties all three queues, returns the input state machine to Idle and clears `err`, `suspend` and all bits of `vld_out`. A packet that was partly received when reset arrived leaves no trace.
- R2: Header bits [1:0] select the queue and header bits [7:2] give the payload length N. The header, the N payload bytes and the check byte are all stored in the selected queue in arrival order.
- R3: A byte is accepted only on a rising edge where `pkt_valid` is high and `suspend` is low. Cycles with `pkt_valid` low pause the packet without losing or duplicating bytes.
- R4: On the edge that accepts the check byte, `err` becomes 1 if that byte differs from the XOR of the header and all payload bytes (even parity per bit column), and 0 otherwise. `err` holds that value until the next header is accepted, which clears it.
- R5: Each packet writes exactly one queue, and the other two queues stay untouched.
- R6: A header with destination value 3 is invalid. That packet is consumed in full and written to no queue, and the next packet is handled normally.
- R7: `suspend` is high while the queue addressed by the current packet is full. In Idle, the address comes from `din[1:0]` while `pkt_valid` is high. While `suspend` is high no byte is taken, and the packet resumes once the reader frees space.
- R8: Each queue shows its oldest byte on its data port with the matching `vld_out` bit high while the queue is non-empty. A byte is removed on each edge at which that queue's `rd_en` bit is high.
- R9: If a queue holds data and no byte has been read from it within 30 cycles of its `vld_out` bit rising, the queue is emptied and its `vld_out` bit falls.
- R10: A header with length 0 is followed directly by the check byte, and the queue receives exactly two bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Input byte |
| pkt_valid | input | 1 | Input byte is present |
| rd_en | input | 3 | Per-queue read enable, bit i for queue i |
| dout_0 | output | 8 | Oldest byte of queue 0 |
| dout_1 | output | 8 | Oldest byte of queue 1 |
| dout_2 | output | 8 | Oldest byte of queue 2 |
| vld_out | output | 3 | Per-queue non-empty flag |
| err | output | 1 | Check byte mismatch on the last packet |
| suspend | output | 1 | Addressed queue is full; sender must hold |

## Verification
The bench targets several corner cases:
- A packet longer than a queue, so the sender must stall on `suspend`. A design that dropped or repeated the stalled byte would show a shifted byte stream at the reader.
- A corrupted check byte followed by a clean packet. A sticky or never-set `err` would be caught.
- A length-zero header. A design that expected a payload byte would swallow the next header.
- An address-3 packet. A design that wrote queue 0 or stalled would be exposed.
- An unread queue that must empty after the timeout but not before it, and a reset in the middle of a packet that must not leave the state machine waiting for payload.

// File: rtl/pkt_rtr_pkg.sv
package pkt_rtr_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int LEN_W  = BYTE_W - ADDR_W;
    localparam int NCH    = 3;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_BODY = 2'd1,
        S_PAR  = 2'd2
    } rx_state_t;
endpackage

// File: rtl/rtr_out_fifo.sv
module rtr_out_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int TMO   = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         vld,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam int TW = $clog2(TMO + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [TW-1:0] age;
    logic          begun;
    logic          push, pop, stale;

    assign vld     = (cnt != '0);
    assign full    = (cnt == CW'(DEPTH));
    assign push    = wr_en && !full;
    assign pop     = rd_en && vld;
    assign stale   = vld && !begun && !pop && (age == TW'(TMO - 1));
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (push && !stale) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || stale) begin
            wp    <= '0;
            rp    <= '0;
            cnt   <= '0;
            age   <= '0;
            begun <= 1'b0;
        end else begin
            if (push) wp <= wp + AW'(1);
            if (pop)  rp <= rp + AW'(1);
            cnt <= cnt + CW'(push) - CW'(pop);
            if (!vld)     begun <= 1'b0;
            else if (pop) begun <= 1'b1;
            if (!vld || begun) age <= '0;
            else if (!pop)     age <= age + TW'(1);
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R8
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !stale) |=> (cnt == $past(cnt) - CW'(1)));

    // R9
    stale_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stale |=> !vld);
endmodule

// File: rtl/rtr_steer.sv
module rtr_steer #(
    parameter int NCH    = 3,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [NCH-1:0]    full,
    output logic [NCH-1:0]    we,
    output logic              tgt_full
);
    for (genvar i = 0; i < NCH; i++) begin : g_we
        assign we[i] = wr && (addr == ADDR_W'(i));
    end

    always_comb begin
        tgt_full = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(i)) tgt_full = full[i];
        end
    end

    // R5
    one_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));

    // R6
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= ADDR_W'(NCH)) |-> (we == '0));
endmodule

// File: rtl/rtr_rx_fsm.sv
module rtr_rx_fsm
    import pkt_rtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] din,
    input  logic              pkt_valid,
    input  logic              tgt_full,
    output logic [ADDR_W-1:0] route_addr,
    output logic              wr_byte,
    output logic              suspend,
    output logic              err
);
    rx_state_t         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [BYTE_W-1:0] acc_q;
    logic              take;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        route_addr = (state_q == S_IDLE) ? din[ADDR_W-1:0] : addr_q;
        suspend    = tgt_full && (pkt_valid || state_q != S_IDLE);
        take       = pkt_valid && !tgt_full;
        wr_byte    = take && (route_addr < ADDR_W'(NCH));
        state_d    = state_q;
        unique case (state_q)
            S_IDLE: if (take) state_d = (din[BYTE_W-1:ADDR_W] == '0) ? S_PAR : S_BODY;
            S_BODY: if (take && rem_q == LEN_W'(1)) state_d = S_PAR;
            S_PAR:  if (take) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
            acc_q  <= '0;
            err    <= 1'b0;
        end else if (take) begin
            unique case (state_q)
                S_IDLE: begin
                    addr_q <= din[ADDR_W-1:0];
                    rem_q  <= din[BYTE_W-1:ADDR_W];
                    acc_q  <= din;
                    err    <= 1'b0;
                end
                S_BODY: begin
                    acc_q <= acc_q ^ din;
                    rem_q <= rem_q - LEN_W'(1);
                end
                S_PAR:   err <= (din != acc_q);
                default: ;
            endcase
        end
    end

    // R7
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> $stable(state_q));

    // R4
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(state_q) == S_PAR));
endmodule

// File: rtl/pkt_router3.sv
module pkt_router3
    import pkt_rtr_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int FLUSH_CYC  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] din,
    input  logic              pkt_valid,
    input  logic [NCH-1:0]    rd_en,
    output logic [BYTE_W-1:0] dout_0,
    output logic [BYTE_W-1:0] dout_1,
    output logic [BYTE_W-1:0] dout_2,
    output logic [NCH-1:0]    vld_out,
    output logic              err,
    output logic              suspend
);
    logic [ADDR_W-1:0] route_addr;
    logic              wr_byte, tgt_full;
    logic [NCH-1:0]    we, full;
    logic [BYTE_W-1:0] dq [NCH];

    rtr_rx_fsm u_rx (
        .clk(clk), .rst_n(rst_n), .din(din), .pkt_valid(pkt_valid),
        .tgt_full(tgt_full), .route_addr(route_addr), .wr_byte(wr_byte),
        .suspend(suspend), .err(err)
    );

    rtr_steer #(.NCH(NCH), .ADDR_W(ADDR_W)) u_steer (
        .clk(clk), .rst_n(rst_n), .addr(route_addr), .wr(wr_byte),
        .full(full), .we(we), .tgt_full(tgt_full)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_q
        rtr_out_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH), .TMO(FLUSH_CYC)) u_q (
            .clk(clk), .rst_n(rst_n), .wr_en(we[i]), .wr_data(din),
            .rd_en(rd_en[i]), .rd_data(dq[i]), .vld(vld_out[i]), .full(full[i])
        );
    end

    assign dout_0 = dq[0];
    assign dout_1 = dq[1];
    assign dout_2 = dq[2];
endmodule

// File: tb/pkt_router3_tb_top.sv
`timescale 1ns/1ps
module pkt_router3_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = '0;
    logic       pkt_valid = 1'b0;
    logic [2:0] rd_en = '0;
    logic [7:0] dout_0, dout_1, dout_2;
    logic [2:0] vld_out;
    logic       err, suspend;

    int runs = 0;
    int fails = 0;
    logic [7:0] pk [0:80];
    int pk_n = 0;

    always #2.5 clk = ~clk;

    pkt_router3 dut_i (
        .clk(clk), .rst_n(rst_n), .din(din), .pkt_valid(pkt_valid),
        .rd_en(rd_en), .dout_0(dout_0), .dout_1(dout_1), .dout_2(dout_2),
        .vld_out(vld_out), .err(err), .suspend(suspend)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dsel(input int ch);
        case (ch)
            0: return dout_0;
            1: return dout_1;
            default: return dout_2;
        endcase
    endfunction

    task automatic build(input int addr, input int len, input bit bad, input int seed);
        logic [7:0] x;
        pk[0] = {6'(len), 2'(addr)};
        x = pk[0];
        for (int i = 0; i < len; i++) begin
            pk[i+1] = 8'(seed * 37 + i * 13 + 5);
            x = x ^ pk[i+1];
        end
        pk[len+1] = bad ? ~x : x;
        pk_n = len + 2;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        din = b;
        pkt_valid = 1'b1;
        #1;
        while (suspend) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic send_pkt(input int gap);
        for (int i = 0; i < pk_n; i++) begin
            send_byte(pk[i]);
            if (gap > 0) begin
                @(negedge clk);
                pkt_valid = 1'b0;
                din = 8'hA5;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic read_pkt(input int ch, input string tag);
        for (int i = 0; i < pk_n; i++) begin
            int tries;
            tries = 0;
            while (!vld_out[ch] && tries < 40) begin
                @(negedge clk);
                tries++;
            end
            chk(vld_out[ch], {tag, " vld"}, 32'(vld_out[ch]), 1);
            chk(dsel(ch) == pk[i], {tag, " byte"}, 32'(dsel(ch)), 32'(pk[i]));
            rd_en[ch] = 1'b1;
            @(negedge clk);
            rd_en[ch] = 1'b0;
        end
        chk(!vld_out[ch], {tag, " empty after"}, 32'(vld_out[ch]), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(vld_out == 3'b000, "R1 vld after reset", 32'(vld_out), 0);
        chk(!err && !suspend, "R1 err/suspend after reset", {30'd0, err, suspend}, 0);
        // partial packet then reset mid-packet
        build(0, 5, 1'b0, 9);
        send_byte(pk[0]);
        send_byte(pk[1]);
        @(negedge clk);
        pkt_valid = 1'b0;
        chk(vld_out[0], "R1 partial stored", 32'(vld_out), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(vld_out == 3'b000, "R1 mid-packet reset empties", 32'(vld_out), 0);
    endtask

    task automatic t_basic;
        build(0, 3, 1'b0, 1);
        send_pkt(0);
        chk(vld_out == 3'b001, "R5 only queue 0 written", 32'(vld_out), 1);
        chk(!err, "R4 good parity", 32'(err), 0);
        read_pkt(0, "R2 R8 queue 0 contents");
    endtask

    task automatic t_parity;
        build(2, 4, 1'b1, 2);
        send_pkt(0);
        chk(err, "R4 bad parity flagged", 32'(err), 1);
        chk(vld_out == 3'b100, "R5 only queue 2 written", 32'(vld_out), 4);
        read_pkt(2, "R2 queue 2 contents");
        chk(err, "R4 err holds", 32'(err), 1);
        build(1, 2, 1'b0, 3);
        send_pkt(0);
        chk(!err, "R4 err cleared by good packet", 32'(err), 0);
        read_pkt(1, "R2 queue 1 contents");
    endtask

    task automatic t_bad_addr;
        build(3, 4, 1'b0, 4);
        send_pkt(0);
        chk(vld_out == 3'b000, "R6 address 3 not stored", 32'(vld_out), 0);
        chk(!suspend, "R6 no stall", 32'(suspend), 0);
        build(1, 1, 1'b0, 5);
        send_pkt(0);
        read_pkt(1, "R6 next packet normal");
    endtask

    task automatic t_zero_len;
        build(1, 0, 1'b0, 6);
        send_pkt(0);
        chk(!err, "R10 zero-length parity", 32'(err), 0);
        read_pkt(1, "R10 two bytes");
        build(0, 1, 1'b0, 7);
        send_pkt(0);
        read_pkt(0, "R10 following packet framed");
    endtask

    task automatic t_gaps;
        build(1, 5, 1'b0, 8);
        send_pkt(2);
        read_pkt(1, "R3 gaps keep order");
    endtask

    task automatic t_suspend;
        build(0, 21, 1'b0, 10);
        fork
            send_pkt(0);
        join_none
        repeat (22) @(negedge clk);
        #1;
        chk(suspend, "R7 suspend when full", 32'(suspend), 1);
        chk(dout_0 == pk[0], "R7 head unchanged", 32'(dout_0), 32'(pk[0]));
        @(negedge clk);
        read_pkt(0, "R7 R3 stalled packet intact");
        repeat (3) @(negedge clk);
        chk(!suspend, "R7 suspend released", 32'(suspend), 0);
    endtask

    task automatic t_timeout;
        build(2, 2, 1'b0, 11);
        send_pkt(0);
        repeat (20) @(negedge clk);
        chk(vld_out[2], "R9 held before timeout", 32'(vld_out), 4);
        repeat (15) @(negedge clk);
        chk(!vld_out[2], "R9 flushed after timeout", 32'(vld_out), 0);
        build(2, 1, 1'b0, 12);
        send_pkt(0);
        read_pkt(2, "R9 queue usable after flush");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_parity();
        t_bad_addr();
        t_zero_len();
        t_gaps();
        t_suspend();
        t_timeout();
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule